// File: doc/BRIEF.md
# Serial Configuration Loader with Gated Logic-Cell Array

This block brings a small array of table-driven logic cells to life after every reset. The configuration of the array is held only in flip-flops, so a reset wipes it. Once reset is released, the loader asks an external serial memory for bits and shifts each delivered bit into one long configuration chain. When the full image has arrived, it raises a done flag and lets the cells drive their outputs.

Each cell holds a 16-entry truth table addressed by its four inputs, plus four control bits. Control bit 0 selects a registered output instead of a combinational one. Control bit 1 inverts the output. Control bits 2 and 3 are spare. The image is sent cell 0 first. Within a cell, table entry 0 comes first, then entries 1 to 15, then the control bits in order. A per-cell flag shows when each cell's share of the image has been received. Until the whole image is in place, every cell output is held low.

Top module: `cfg_loader`

## Requirements
- R1: After reset, cfgDone is 0, every cellLoaded bit is 0, every cellOut bit is 0 and memEn is 1. memEn stays 1 until the load completes.
- R2: A bit is taken from memBit only on a clock edge where memEn and memValid are both 1. Cycles with memValid low change neither the progress flags nor the completion time.
- R3: cellLoaded[i] is 1 exactly when at least (i+1)*CELL_BITS bits have been taken. Once set, it stays set until reset, so the flags fill from bit 0 upward.
- R4: cfgDone rises on the edge that takes bit number NUM_CELLS*CELL_BITS (80 by default). memEn falls on that same edge, and cfgDone then stays high until reset.
- R5: While cfgDone is 0, every cellOut bit is 0 whatever cellIn holds.
- R6: Once done, a cell in combinational mode drives table[addr] XOR invert. Here addr is cellIn[4i+3:4i], table entry j is stream bit i*20+j, the invert flag is stream bit i*20+17, and stream bits i*20+18 and i*20+19 have no effect.
- R7: Once done, a cell whose mode bit (stream bit i*20+16) is 1 drives, one clock later, the value R6 gives for its inputs.
- R8: After done, memValid and memBit are ignored, and the loaded function does not change.
- R9: Reset during or after a load clears the image, drops cfgDone and every cellLoaded bit, and forces cellOut to 0. The next load restarts from stream bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| memEn | output | 1 | Request to the serial memory for more bits |
| memValid | input | 1 | memBit holds a valid stream bit this cycle |
| memBit | input | 1 | Serial configuration bit |
| cellIn | input | NUM_CELLS*LUT_IN | Four table-address inputs per cell, cell 0 in the low bits |
| cellOut | output | NUM_CELLS | One output per cell, held at 0 until done |
| cellLoaded | output | NUM_CELLS | Per-cell flag showing its share of the image has arrived |
| cfgDone | output | 1 | The whole image is loaded and the outputs are live |

## Verification
Every cycle, the assertions check the following: outputs stay low before done, done persists, and the progress flags are monotonic and fill from bit 0 upward. They also keep their own count of accepted bits and tie done and the memory request to it. Only the bench scenarios can show that a bit lands in the right table entry, that invert and register modes behave, that the spare bits do nothing, and that stray stream bits after completion leave the function intact. The same holds for a reset in mid-load: only the scenarios show that it discards the partial image, so that a different fresh image loads cleanly.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  // Strobes from the load control to the datapath
  typedef struct packed {
    logic shift;  // take memBit into the chain this cycle
    logic live;   // image complete, cell outputs enabled
  } cfgStrobe_t;
endpackage

// File: rtl/cfg_loader_ctrl.sv
module cfg_loader_ctrl
  import cfg_loader_pkg::*;
#(
  parameter int NUM_CELLS = 4,
  parameter int CELL_BITS = 20
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 memValid,
  output cfgStrobe_t           strobe,
  output logic                 memEn,
  output logic                 cfgDone,
  output logic [NUM_CELLS-1:0] cellLoaded
);
  localparam int TOTAL = NUM_CELLS * CELL_BITS;
  localparam int CNT_W = $clog2(TOTAL + 1);

  typedef enum logic {ST_LOAD, ST_LIVE} loadState_t;

  loadState_t state;
  logic [CNT_W-1:0] bitCount;
  logic accept;

  assign accept = (state == ST_LOAD) && memValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_LOAD;
      bitCount <= '0;
    end else if (accept) begin
      bitCount <= bitCount + 1'b1;
      if (bitCount == CNT_W'(TOTAL - 1)) state <= ST_LIVE;
    end
  end

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_progress
    localparam int THR = (i + 1) * CELL_BITS;
    assign cellLoaded[i] = (bitCount >= CNT_W'(THR));
  end

  assign strobe.shift = accept;
  assign strobe.live  = (state == ST_LIVE);
  assign memEn        = (state == ST_LOAD);
  assign cfgDone      = (state == ST_LIVE);
endmodule

// File: rtl/cfg_logic_cell.sv
module cfg_logic_cell #(
  parameter int LUT_IN = 4,
  localparam int TBL = 2 ** LUT_IN,
  localparam int CFG_W = TBL + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              live,
  input  logic [CFG_W-1:0]  cfgWord,
  input  logic [LUT_IN-1:0] sel,
  output logic              out
);
  localparam int REG_POS = TBL;
  localparam int INV_POS = TBL + 1;

  logic lutVal;
  logic held;

  assign lutVal = cfgWord[sel] ^ cfgWord[INV_POS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) held <= 1'b0;
    else       held <= live & lutVal;
  end

  assign out = live & (cfgWord[REG_POS] ? held : lutVal);
endmodule

// File: rtl/cfg_loader_dpath.sv
module cfg_loader_dpath
  import cfg_loader_pkg::*;
#(
  parameter int NUM_CELLS = 4,
  parameter int CELL_BITS = 20,
  parameter int LUT_IN    = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  cfgStrobe_t                  strobe,
  input  logic                        memBit,
  input  logic [NUM_CELLS*LUT_IN-1:0] cellIn,
  output logic [NUM_CELLS-1:0]        cellOut
);
  localparam int TOTAL = NUM_CELLS * CELL_BITS;
  localparam int CFG_W = 2 ** LUT_IN + 2;

  // First stream bit ends at chain[0] once the full image is in
  logic [TOTAL-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             chain <= '0;
    else if (strobe.shift) chain <= {memBit, chain[TOTAL-1:1]};
  end

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
    cfg_logic_cell #(.LUT_IN(LUT_IN)) u_cell (
      .clk    (clk),
      .rstN   (rstN),
      .live   (strobe.live),
      .cfgWord(chain[i*CELL_BITS +: CFG_W]),
      .sel    (cellIn[i*LUT_IN +: LUT_IN]),
      .out    (cellOut[i])
    );
  end
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int NUM_CELLS = 4,
  parameter int CELL_BITS = 20,
  parameter int LUT_IN    = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  output logic                        memEn,
  input  logic                        memValid,
  input  logic                        memBit,
  input  logic [NUM_CELLS*LUT_IN-1:0] cellIn,
  output logic [NUM_CELLS-1:0]        cellOut,
  output logic [NUM_CELLS-1:0]        cellLoaded,
  output logic                        cfgDone
);
  cfgStrobe_t strobe;

  cfg_loader_ctrl #(.NUM_CELLS(NUM_CELLS), .CELL_BITS(CELL_BITS)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .memValid  (memValid),
    .strobe    (strobe),
    .memEn     (memEn),
    .cfgDone   (cfgDone),
    .cellLoaded(cellLoaded)
  );

  cfg_loader_dpath #(.NUM_CELLS(NUM_CELLS), .CELL_BITS(CELL_BITS), .LUT_IN(LUT_IN)) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .memBit (memBit),
    .cellIn (cellIn),
    .cellOut(cellOut)
  );
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
  parameter int NUM_CELLS = 4,
  parameter int CELL_BITS = 20
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 memEn,
  input logic                 memValid,
  input logic                 cfgDone,
  input logic [NUM_CELLS-1:0] cellLoaded,
  input logic [NUM_CELLS-1:0] cellOut
);
  localparam int TOTAL = NUM_CELLS * CELL_BITS;
  localparam int CNT_W = $clog2(TOTAL + 1);

  // Independent tally of bits accepted since reset
  logic [CNT_W-1:0] seen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seen <= '0;
    else if (memEn && memValid && seen != CNT_W'(TOTAL)) seen <= seen + 1'b1;
  end

  // R4
  done_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgDone == (seen == CNT_W'(TOTAL)));

  // R1
  request_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    memEn |-> (seen < CNT_W'(TOTAL)));

  // R4
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgDone |=> cfgDone);

  // R5
  gated_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgDone |-> (cellOut == '0));

  // R3
  loaded_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cellLoaded & $past(cellLoaded)) == $past(cellLoaded));

  // R3
  loaded_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((cellLoaded + 1'b1) & cellLoaded) == '0);
endmodule

bind cfg_loader cfg_loader_chk #(.NUM_CELLS(NUM_CELLS), .CELL_BITS(CELL_BITS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .memEn     (memEn),
  .memValid  (memValid),
  .cfgDone   (cfgDone),
  .cellLoaded(cellLoaded),
  .cellOut   (cellOut)
);

// File: tb/cfg_loader_bench.sv
`timescale 1ns/1ps
module cfg_loader_bench;
  localparam int NC    = 4;
  localparam int CB    = 20;
  localparam int LI    = 4;
  localparam int TOTAL = NC * CB;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic memValid = 1'b0;
  logic memBit = 1'b0;
  logic [NC*LI-1:0] cellIn = '0;
  logic memEn;
  logic [NC-1:0] cellOut;
  logic [NC-1:0] cellLoaded;
  logic cfgDone;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cfg_loader #(.NUM_CELLS(NC), .CELL_BITS(CB), .LUT_IN(LI)) u_cfg_loader (
    .clk(clk), .rstN(rstN), .memEn(memEn), .memValid(memValid), .memBit(memBit),
    .cellIn(cellIn), .cellOut(cellOut), .cellLoaded(cellLoaded), .cfgDone(cfgDone)
  );

  // Images: cell word = {spare2, inv, reg, table16}
  localparam logic [TOTAL-1:0] CFG_A = {
    {4'b0000, 16'hA5C3},
    {4'b1100, 16'hFFFE},
    {4'b0010, 16'h6996},
    {4'b0000, 16'h8000}};
  localparam logic [TOTAL-1:0] CFG_B = {
    {4'b0010, 16'h0000},
    {4'b0011, 16'hF0F0},
    {4'b0001, 16'h00FF},
    {4'b0000, 16'h1234}};

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NC-1:0] expLoaded(input int n);
    logic [NC-1:0] v;
    for (int i = 0; i < NC; i++) v[i] = (n >= (i + 1) * CB);
    return v;
  endfunction

  function automatic logic expCell(input logic [TOTAL-1:0] cfg, input int i, input logic [3:0] a);
    return cfg[i*CB + int'(a)] ^ cfg[i*CB + 17];
  endfunction

  task automatic doReset();
    rstN = 1'b0;
    memValid = 1'b0;
    tick();
    // R1 and R9: everything cleared while reset is held
    check("R9 done", 32'(cfgDone), 0);
    check("R9 loaded", 32'(cellLoaded), 0);
    check("R9 out", 32'(cellOut), 0);
    rstN = 1'b1;
    tick();
    check("R1 memEn", 32'(memEn), 1);
    check("R1 done", 32'(cfgDone), 0);
  endtask

  // Send nBits of cfg; gapEvery>0 inserts idle cycles with memBit=1
  task automatic sendStream(input logic [TOTAL-1:0] cfg, input int nBits, input int gapEvery);
    for (int k = 0; k < nBits; k++) begin
      if (gapEvery > 0 && (k % gapEvery) == gapEvery - 1) begin
        memValid = 1'b0;
        memBit = 1'b1;
        tick();
        check("R2 gap loaded", 32'(cellLoaded), 32'(expLoaded(k)));
        check("R2 gap done", 32'(cfgDone), 0);
      end
      memValid = 1'b1;
      memBit = cfg[k];
      cellIn = 16'(k * 16'h9E37);
      tick();
      check("R3 loaded", 32'(cellLoaded), 32'(expLoaded(k + 1)));
      check("R4 done", 32'(cfgDone), 32'(k + 1 == TOTAL));
      check("R4 memEn", 32'(memEn), 32'(k + 1 != TOTAL));
      if (k + 1 < TOTAL) check("R5 gated", 32'(cellOut), 0);
    end
    memValid = 1'b0;
    memBit = 1'b0;
  endtask

  task automatic checkComb(input logic [TOTAL-1:0] cfg, input string req);
    for (int a = 0; a < 16; a++) begin
      cellIn = {NC{4'(a)}};
      #1;
      for (int i = 0; i < NC; i++)
        check(req, 32'(cellOut[i]), 32'(expCell(cfg, i, 4'(a))));
    end
  endtask

  task automatic testReset();
    rstN = 1'b0;
    tick();
    check("R1 done", 32'(cfgDone), 0);
    check("R1 loaded", 32'(cellLoaded), 0);
    check("R1 out", 32'(cellOut), 0);
    check("R1 memEn", 32'(memEn), 1);
    rstN = 1'b1;
    tick();
  endtask

  task automatic testLoadWithGaps();
    sendStream(CFG_A, TOTAL, 3);
    repeat (3) tick();
    check("R4 done held", 32'(cfgDone), 1);
    check("R4 memEn low", 32'(memEn), 0);
  endtask

  task automatic testFunction();
    checkComb(CFG_A, "R6 comb");
  endtask

  task automatic testIgnoreAfterDone();
    for (int k = 0; k < 40; k++) begin
      memValid = 1'b1;
      memBit = ~CFG_A[k];
      tick();
    end
    memValid = 1'b0;
    check("R8 done", 32'(cfgDone), 1);
    check("R8 loaded", 32'(cellLoaded), 32'({NC{1'b1}}));
    checkComb(CFG_A, "R8 unchanged");
  endtask

  task automatic testMidReset();
    doReset();
    sendStream(CFG_B, 50, 0);
    doReset();
    sendStream(CFG_A, TOTAL, 0);
    checkComb(CFG_A, "R9 fresh load");
  endtask

  task automatic testRegistered();
    logic [3:0] prev;
    logic [3:0] seq [8] = '{4'h3, 4'hC, 4'h7, 4'h8, 4'h0, 4'hF, 4'h5, 4'hA};
    doReset();
    sendStream(CFG_B, TOTAL, 4);
    cellIn = '0;
    tick();
    tick();
    prev = 4'h0;
    for (int s = 0; s < 8; s++) begin
      cellIn = {NC{seq[s]}};
      #1;
      check("R6 cell0", 32'(cellOut[0]), 32'(expCell(CFG_B, 0, seq[s])));
      check("R6 cell3", 32'(cellOut[3]), 32'(expCell(CFG_B, 3, seq[s])));
      check("R7 cell1 old", 32'(cellOut[1]), 32'(expCell(CFG_B, 1, prev)));
      check("R7 cell2 old", 32'(cellOut[2]), 32'(expCell(CFG_B, 2, prev)));
      tick();
      check("R7 cell1 new", 32'(cellOut[1]), 32'(expCell(CFG_B, 1, seq[s])));
      check("R7 cell2 new", 32'(cellOut[2]), 32'(expCell(CFG_B, 2, seq[s])));
      prev = seq[s];
    end
  endtask

  initial begin
    testReset();
    testLoadWithGaps();
    testFunction();
    testIgnoreAfterDone();
    testMidReset();
    testRegistered();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog act=%0h exp=%0h", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end
endmodule